// File: doc/BRIEF.md
# CAN Bit Timing Resynchronization Unit

This block produces the bit-level timing of a CAN node from the system clock. A programmable prescaler divides the clock into time quanta. Each nominal bit is built from a one-quantum synchronization segment, then a first phase segment that ends at the sample point, then a second phase segment that ends at the transmit point. The block strobes the sample point, holds the bit it sampled, strobes the transmit point, and flags the start of every bit.

The block watches the received line for recessive-to-dominant transitions. While the bus is idle, the first such transition restarts the bit at once (hard synchronization). Later transitions move the bit boundaries, by no more than a programmed jump width, to follow the transmitter. Timing fields load only while standby is asserted. Standby also freezes the timing chain.

There is no data stream here. All pins are plain level or strobe signals, and nothing waits on a consumer, so no back-pressure exists. Line levels use 1 for recessive and 0 for dominant.

Top module: `can_bit_timer`

## Requirements
- R1: With no bus edge, `bit_start_o` pulses once every (BRP+1)*(3+TS1+TS2) clocks, where BRP=`cfg_brp_i`, TS1=`cfg_ts1_i` and TS2=`cfg_ts2_i` are the loaded values. A quantum is BRP+1 clocks. The bit holds 1 synchronization quantum, TS1+1 quanta in the first phase segment and TS2+1 quanta in the second.
- R2: `sample_o` pulses (BRP+1)*(TS1+2) clocks after `bit_start_o` when no edge adjusts the bit. At that pulse `rx_bit_o` takes the value that `rx_i` had at the sampling clock edge. `rx_bit_o` changes at no other time and resets to 1.
- R3: `tx_point_o` pulses when the second phase segment ends, whether it ends normally or early, and always together with `bit_start_o`.
- R4: Timing fields are loaded on a clock edge where both `cfg_we_i` and `standby_i` are 1. A write while `standby_i` is 0 is ignored.
- R5: While `standby_i` is 1, all strobes are 0 and the timing chain is held at the start of a synchronization segment. The unit treats the bus as idle when it leaves standby. All fields reset to 0.
- R6: When the bus is idle, a falling edge on `rx_i` (1 before the clock edge, 0 at it) restarts the bit. `bit_start_o` pulses in the next cycle, with no `tx_point_o`, and the bus is then no longer idle.
- R7: A valid edge in the first phase segment, seen q quanta after the bit started, lengthens that segment by min(q, SJW+1) quanta, where SJW=`cfg_sjw_i`. This delays the sample point.
- R8: A valid edge in the second phase segment, seen r quanta before its programmed end with r > SJW+1, shortens that segment by SJW+1 quanta.
- R9: A valid edge in the second phase segment with r <= SJW+1 ends the bit at once. `tx_point_o` and `bit_start_o` pulse in the next cycle.
- R10: An edge is valid only if it is the first transition of `rx_i` in the current bit, the bus is not idle, and `tx_i` is 0 (dominant) at that edge. Any other edge changes no timing.
- R11: A lengthening or shortening applies to the current bit only. The following bit uses the loaded lengths.
- R12: After IDLE_BITS consecutive recessive samples the bus counts as idle. A dominant sample clears both the idle state and the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| standby_i | input | 1 | Standby / configuration mode; holds timing |
| cfg_we_i | input | 1 | Write strobe for the timing fields |
| cfg_brp_i | input | 6 | Prescaler field; quantum = field+1 clocks |
| cfg_ts1_i | input | 4 | First phase segment field; length = field+1 quanta |
| cfg_ts2_i | input | 3 | Second phase segment field; length = field+1 quanta |
| cfg_sjw_i | input | 2 | Jump width field; width = field+1 quanta |
| rx_i | input | 1 | Received line level, 1 = recessive |
| tx_i | input | 1 | Level this node drives, 1 = recessive |
| sample_o | output | 1 | One-cycle sample-point strobe |
| rx_bit_o | output | 1 | Bit captured at the last sample point |
| tx_point_o | output | 1 | One-cycle transmit-point strobe |
| bit_start_o | output | 1 | One-cycle pulse when a new bit begins |

## Verification
The assertions take `rx_i` to be already synchronous to `clk`, since the block contains no synchronizer. The bench changes `rx_i` and `tx_i` only on the falling clock edge. The assertions also take it that configuration changes only through the standby path. The stimulus holds the line steady for whole bits and then drops it at chosen quanta: inside the synchronization segment, early and late in the first phase segment, and far from and near the end of the second phase segment. It drops the line only when a rise earlier in the bit has not already used up that bit's one valid edge, except in the case that tests exactly that.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  parameter int BRP_W = 6;
  parameter int TS1_W = 4;
  parameter int TS2_W = 3;
  parameter int SJW_W = 2;
  // segment counters must hold the longest stretched first segment
  localparam int CNT_W = TS1_W + 2;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_ONE  = 2'd1,
    SEG_TWO  = 2'd2
  } seg_e;

  typedef struct packed {
    logic [BRP_W-1:0] brp;
    logic [TS1_W-1:0] ts1;
    logic [TS2_W-1:0] ts2;
    logic [SJW_W-1:0] sjw;
  } cbt_cfg_t;
endpackage

// File: rtl/cbt_quantum_div.sv
module cbt_quantum_div #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold_i,
  input  logic         restart_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  assign tick_o = ~hold_i & ~restart_i & (cnt_q == div_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (hold_i | restart_i) cnt_q <= '0;
    else if (cnt_q == div_i)     cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cbt_segment_fsm.sv
module cbt_segment_fsm
  import cbt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  input  logic             tick_i,
  input  logic [TS1_W-1:0] ts1_i,
  input  logic [TS2_W-1:0] ts2_i,
  input  logic [SJW_W-1:0] sjw_i,
  input  logic             valid_i,
  input  logic             hard_i,
  output logic             sample_now_o,
  output logic             tx_now_o,
  output logic             start_now_o,
  output logic             sync_now_o
);
  seg_e             seg_q;
  logic [CNT_W-1:0] pc_q, lim_q;
  logic [CNT_W-1:0] jw, err1, adj1, rem2, lim_eff, len1, len2;
  logic             early, done;

  assign jw   = CNT_W'(sjw_i) + 1'b1;
  assign len1 = CNT_W'(ts1_i) + 1'b1;
  assign len2 = CNT_W'(ts2_i) + 1'b1;
  assign err1 = pc_q + 1'b1;
  assign adj1 = (err1 < jw) ? err1 : jw;
  assign rem2 = lim_q - pc_q;

  assign early = valid_i && (seg_q == SEG_TWO) && (rem2 <= jw);

  always_comb begin
    lim_eff = lim_q;
    if (valid_i && seg_q == SEG_ONE)             lim_eff = lim_q + adj1;
    else if (valid_i && seg_q == SEG_TWO && !early) lim_eff = lim_q - jw;
  end

  assign done         = tick_i && (pc_q == lim_eff - 1'b1);
  assign sync_now_o   = ~hold_i & (hard_i | early);
  assign sample_now_o = ~hold_i & ~sync_now_o & done & (seg_q == SEG_ONE);
  assign tx_now_o     = ~hold_i & (early | (~hard_i & done & (seg_q == SEG_TWO)));
  assign start_now_o  = ~hold_i & (sync_now_o | (done & (seg_q == SEG_TWO)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= SEG_SYNC;
      pc_q  <= '0;
      lim_q <= CNT_W'(1);
    end else if (hold_i || sync_now_o) begin
      seg_q <= SEG_SYNC;
      pc_q  <= '0;
      lim_q <= CNT_W'(1);
    end else if (done) begin
      pc_q <= '0;
      unique case (seg_q)
        SEG_SYNC: begin seg_q <= SEG_ONE;  lim_q <= len1;      end
        SEG_ONE:  begin seg_q <= SEG_TWO;  lim_q <= len2;      end
        default:  begin seg_q <= SEG_SYNC; lim_q <= CNT_W'(1); end
      endcase
    end else begin
      lim_q <= lim_eff;
      if (tick_i) pc_q <= pc_q + 1'b1;
    end
  end
endmodule

// File: rtl/cbt_idle_track.sv
module cbt_idle_track #(
  parameter int IDLE_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  input  logic hard_i,
  input  logic sample_i,
  input  logic rx_i,
  output logic idle_o
);
  localparam int CW = $clog2(IDLE_BITS + 1);
  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_o <= 1'b1;
      run_q  <= '0;
    end else if (hold_i) begin
      idle_o <= 1'b1;
      run_q  <= '0;
    end else if (hard_i) begin
      idle_o <= 1'b0;
      run_q  <= '0;
    end else if (sample_i) begin
      if (!rx_i) begin
        idle_o <= 1'b0;
        run_q  <= '0;
      end else if (run_q == CW'(IDLE_BITS - 1)) begin
        idle_o <= 1'b1;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import cbt_pkg::*;
#(
  parameter int IDLE_BITS = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby_i,
  input  logic             cfg_we_i,
  input  logic [BRP_W-1:0] cfg_brp_i,
  input  logic [TS1_W-1:0] cfg_ts1_i,
  input  logic [TS2_W-1:0] cfg_ts2_i,
  input  logic [SJW_W-1:0] cfg_sjw_i,
  input  logic             rx_i,
  input  logic             tx_i,
  output logic             sample_o,
  output logic             rx_bit_o,
  output logic             tx_point_o,
  output logic             bit_start_o
);
  cbt_cfg_t cfg_q;
  logic     rx_q, fall, any_edge, idle, seen_q, hard, valid;
  logic     tq_tick, sample_now, tx_now, start_now, sync_now;

  // configuration only loads in standby
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cfg_q <= '0;
    else if (standby_i && cfg_we_i) cfg_q <= '{brp: cfg_brp_i, ts1: cfg_ts1_i,
                                               ts2: cfg_ts2_i, sjw: cfg_sjw_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_q <= 1'b1;
    else        rx_q <= rx_i;
  end

  assign fall     = rx_q & ~rx_i;
  assign any_edge = rx_q ^ rx_i;
  assign hard     = fall & idle & ~standby_i;
  assign valid    = fall & ~seen_q & ~tx_i & ~idle & ~standby_i;

  // one edge per bit may adjust timing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         seen_q <= 1'b0;
    else if (standby_i) seen_q <= 1'b0;
    else if (sync_now)  seen_q <= 1'b1;
    else if (start_now) seen_q <= 1'b0;
    else if (any_edge)  seen_q <= 1'b1;
  end

  cbt_quantum_div #(.W(BRP_W)) u_tq (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_i    (standby_i),
    .restart_i (sync_now),
    .div_i     (cfg_q.brp),
    .tick_o    (tq_tick)
  );

  cbt_segment_fsm u_seg (
    .clk          (clk),
    .rst_n        (rst_n),
    .hold_i       (standby_i),
    .tick_i       (tq_tick),
    .ts1_i        (cfg_q.ts1),
    .ts2_i        (cfg_q.ts2),
    .sjw_i        (cfg_q.sjw),
    .valid_i      (valid),
    .hard_i       (hard),
    .sample_now_o (sample_now),
    .tx_now_o     (tx_now),
    .start_now_o  (start_now),
    .sync_now_o   (sync_now)
  );

  cbt_idle_track #(.IDLE_BITS(IDLE_BITS)) u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_i   (standby_i),
    .hard_i   (hard),
    .sample_i (sample_now),
    .rx_i     (rx_i),
    .idle_o   (idle)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_o    <= 1'b0;
      tx_point_o  <= 1'b0;
      bit_start_o <= 1'b0;
      rx_bit_o    <= 1'b1;
    end else begin
      sample_o    <= sample_now;
      tx_point_o  <= tx_now;
      bit_start_o <= start_now;
      if (sample_now) rx_bit_o <= rx_i;
    end
  end
endmodule

// File: rtl/can_bit_timer_checker.sv
module can_bit_timer_checker
  import cbt_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     standby_i,
  input logic     sample_o,
  input logic     tx_point_o,
  input logic     bit_start_o,
  input logic     rx_bit_o,
  input cbt_cfg_t cfg_word
);
  logic since_sample;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           since_sample <= 1'b0;
    else if (sample_o)    since_sample <= 1'b1;
    else if (bit_start_o) since_sample <= 1'b0;
  end

  // R1: a bit lasts at least three quanta, so starts never abut
  assert_bit_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bit_start_o |=> !bit_start_o);

  // R2: at most one sample point per bit
  assert_single_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> !since_sample);

  // R2: captured bit only moves with the sample strobe
  assert_rxbit_on_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_o |-> $stable(rx_bit_o));

  // R3: transmit point always opens a new bit
  assert_tx_with_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_point_o |-> bit_start_o);

  // R3: sample and transmit points never coincide
  assert_points_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_o && tx_point_o));

  // R4: timing fields frozen outside standby
  assert_cfg_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !standby_i |=> $stable(cfg_word));

  // R5: standby silences every strobe
  assert_quiet_standby_R5: assert property (@(posedge clk) disable iff (!rst_n)
    standby_i |=> (!sample_o && !tx_point_o && !bit_start_o));
endmodule

bind can_bit_timer can_bit_timer_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .standby_i   (standby_i),
  .sample_o    (sample_o),
  .tx_point_o  (tx_point_o),
  .bit_start_o (bit_start_o),
  .rx_bit_o    (rx_bit_o),
  .cfg_word    (cfg_q)
);

// File: tb/can_bit_timer_tb.sv
module can_bit_timer_tb;
  import cbt_pkg::*;
  localparam int IDLE = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic standby = 1'b1, we = 1'b0, rx = 1'b1, tx = 1'b1;
  logic [BRP_W-1:0] brp = '0;
  logic [TS1_W-1:0] ts1 = '0;
  logic [TS2_W-1:0] ts2 = '0;
  logic [SJW_W-1:0] sjw = '0;
  logic sample_o, rx_bit_o, tx_point_o, bit_start_o;

  always #2 clk = ~clk;

  can_bit_timer #(.IDLE_BITS(IDLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .standby_i(standby), .cfg_we_i(we),
    .cfg_brp_i(brp), .cfg_ts1_i(ts1), .cfg_ts2_i(ts2), .cfg_sjw_i(sjw),
    .rx_i(rx), .tx_i(tx), .sample_o(sample_o), .rx_bit_o(rx_bit_o),
    .tx_point_o(tx_point_o), .bit_start_o(bit_start_o)
  );

  int n_vec = 0, n_bad = 0, cyc = 0;
  string cur_req = "R5";

  // behavioural reference state
  int m_brp = 0, m_ts1 = 0, m_ts2 = 0, m_sjw = 0;
  int m_qc = 0, m_q = 0, m_ext = 0, m_cut = 0, m_icnt = 0;
  bit m_seen = 0, m_idle = 1, m_prev = 1;
  bit e_sample = 0, e_tx = 0, e_bs = 0, e_rxbit = 1;

  task automatic model_step();
    int L1, L2, J, end1, endb, rem;
    bit fall, anyc, hard, valid, restart, bitend, ns, ntx, nbs;
    fall = m_prev && !rx;
    anyc = (m_prev != rx);
    ns = 0; ntx = 0; nbs = 0;
    L1 = m_ts1 + 1; L2 = m_ts2 + 1; J = m_sjw + 1;
    if (standby) begin
      m_qc = 0; m_q = 0; m_ext = 0; m_cut = 0; m_seen = 0; m_idle = 1; m_icnt = 0;
    end else begin
      hard = fall && m_idle;
      valid = fall && !m_seen && !tx && !m_idle;
      restart = 0;
      end1 = 1 + L1 + m_ext;
      endb = end1 + L2 - m_cut;
      if (hard) begin
        restart = 1; m_idle = 0; m_icnt = 0;
      end else if (valid) begin
        if (m_q > 0 && m_q < end1) m_ext = (m_q < J) ? m_q : J;
        else if (m_q >= end1) begin
          rem = endb - m_q;
          if (rem <= J) begin restart = 1; ntx = 1; end
          else m_cut = J;
        end
      end
      if (restart) begin
        nbs = 1; m_qc = 0; m_q = 0; m_ext = 0; m_cut = 0; m_seen = 1;
      end else begin
        end1 = 1 + L1 + m_ext;
        endb = end1 + L2 - m_cut;
        bitend = 0;
        if (m_qc == m_brp) begin
          m_qc = 0; m_q++;
          if (m_q == end1) ns = 1;
          if (m_q == endb) bitend = 1;
        end else m_qc++;
        if (bitend) begin
          m_q = 0; m_ext = 0; m_cut = 0; m_seen = 0; ntx = 1; nbs = 1;
        end else if (anyc) m_seen = 1;
        if (ns) begin
          e_rxbit = rx;
          if (rx) begin m_icnt++; if (m_icnt >= IDLE) m_idle = 1; end
          else begin m_icnt = 0; m_idle = 0; end
        end
      end
    end
    m_prev = rx;
    e_sample = ns; e_tx = ntx; e_bs = nbs;
    if (standby && we) begin
      m_brp = int'(brp); m_ts1 = int'(ts1); m_ts2 = int'(ts2); m_sjw = int'(sjw);
    end
  endtask

  task automatic compare();
    n_vec++;
    if (sample_o !== e_sample || tx_point_o !== e_tx ||
        bit_start_o !== e_bs || rx_bit_o !== e_rxbit) begin
      n_bad++;
      $display("FAIL %s cycle %0d: sample/rxbit/tx/start = %b%b%b%b expected %b%b%b%b",
               cur_req, cyc, sample_o, rx_bit_o, tx_point_o, bit_start_o,
               e_sample, e_rxbit, e_tx, e_bs);
    end
  endtask

  task automatic step();
    model_step();
    @(negedge clk);
    compare();
    we = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic to_start();
    for (int i = 0; i < 5000; i++) begin
      step();
      if (e_bs) break;
    end
  endtask

  task automatic load_cfg(input int b, input int t1, input int t2, input int j);
    standby = 1'b1; step();
    brp = BRP_W'(b); ts1 = TS1_W'(t1); ts2 = TS2_W'(t2); sjw = SJW_W'(j);
    we = 1'b1; step();
    standby = 1'b0; rx = 1'b1; tx = 1'b1;
  endtask

  // make rx recessive in one bit, then drop it q quanta into the next bit
  task automatic edge_at(input int q, input logic txv, input string req);
    to_start();
    rx = 1'b1;
    to_start();
    cur_req = req;
    run(q * (m_brp + 1));
    rx = 1'b0; tx = txv;
    to_start();
    cur_req = "R11";
    to_start();
    to_start();
    tx = 1'b1;
  endtask

  // leave idle with a hard synchronization
  task automatic leave_idle();
    cur_req = "R6";
    run(7);
    rx = 1'b0;
    run(3);
    to_start();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: cycle %0d expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R5: reset state
    n_vec++;
    if (sample_o !== 1'b0 || tx_point_o !== 1'b0 || bit_start_o !== 1'b0 || rx_bit_o !== 1'b1) begin
      n_bad++;
      $display("FAIL R5 reset: %b%b%b%b expected 0100", sample_o, rx_bit_o, tx_point_o, bit_start_o);
    end
    rst_n = 1'b1;
    cur_req = "R5";
    run(5);

    // config A: quantum 2 clocks, seg1 6, seg2 3, jump 2
    cur_req = "R4";
    load_cfg(1, 5, 2, 1);
    cur_req = "R1";
    run(70);
    cur_req = "R2";
    run(30);
    leave_idle();
    cur_req = "R3";
    run(60);
    edge_at(2, 1'b0, "R7");   // error 2 within jump width
    edge_at(5, 1'b0, "R7");   // error 5 capped at 2
    edge_at(7, 1'b0, "R8");   // 3 left > 2: shorten
    edge_at(8, 1'b0, "R9");   // 2 left: immediate end
    edge_at(9, 1'b0, "R9");
    edge_at(0, 1'b0, "R10");  // in sync segment: no adjustment
    edge_at(3, 1'b1, "R10");  // node sends recessive: ignored

    // R10: a rise then a fall in the same bit; the fall is not the first transition
    to_start();
    cur_req = "R10";
    run(4);
    rx = 1'b1;
    run(4);
    rx = 1'b0; tx = 1'b0;
    to_start();
    to_start();

    // R4: write outside standby is ignored
    cur_req = "R4";
    brp = 6'd5; ts1 = 4'd1; ts2 = 3'd0; sjw = 2'd3; we = 1'b1;
    step();
    run(100);

    // R12: recessive run makes the bus idle, then any fall hard-syncs
    cur_req = "R12";
    rx = 1'b1;
    for (int i = 0; i < IDLE + 2; i++) to_start();
    run(9);
    rx = 1'b0;
    run(3);
    to_start();
    to_start();

    // config B: quantum 1 clock, seg1 3, seg2 2, jump 4
    cur_req = "R4";
    load_cfg(0, 2, 1, 3);
    cur_req = "R1";
    run(40);
    leave_idle();
    edge_at(3, 1'b0, "R7");
    edge_at(4, 1'b0, "R9");
    edge_at(5, 1'b0, "R9");

    // config C: long segments, quantum 3 clocks, jump 4
    cur_req = "R4";
    load_cfg(2, 15, 7, 3);
    cur_req = "R2";
    run(200);
    leave_idle();
    edge_at(10, 1'b0, "R7");
    edge_at(19, 1'b0, "R8");
    edge_at(23, 1'b0, "R9");

    // R5: standby mid-bit silences strobes
    cur_req = "R5";
    run(11);
    standby = 1'b1;
    run(30);
    standby = 1'b0;
    cur_req = "R1";
    run(200);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule